// File: doc/BRIEF.md
# Eight-Point Forward DCT Pipeline

This block computes an orthonormal eight-point forward discrete cosine transform on one row of signed samples per clock. A row of eight samples is presented together with a valid flag. Four clock edges later the eight coefficients come out together, also flagged valid. Rows may arrive back to back or with gaps of any length. Results leave in the same order the rows went in.

The datapath is a fast flow graph with four register stages. Stage one folds the row into sums and differences of mirrored samples. Stage two splits the even half into a second butterfly and rotates the odd half. Stage three finishes both halves. Stage four applies the last odd-half scaling and rounds all eight results to integers. Each rotation uses the shared-product form, which needs three constant multiplies instead of four. The flow graph core has eleven constant multiplies in total. The orthonormal scaling is folded into the rotation constants, and two more constant multiplies normalise the DC and middle terms. Internal values carry four fraction bits, so only one rounding reaches the output.

A stage register loads only when a valid row is passing through it. When no row is in flight the outputs do not toggle.

Top module: `dct8_fast`

## Requirements
- R1: A row sampled with `in_valid` high at some clock edge produces `out_valid` high right after the fourth edge, counting the sampling edge as the first. `out_valid` is never high unless a row was sampled exactly four edges earlier.
- R2: While `rst_n` is low, `out_valid` is 0 and `out_coefs` is all zero. A row still in flight when reset is asserted never comes out.
- R3: Coefficient k is the value ½·c(k)·Σₓ f(x)·cos((2x+1)kπ/16), where c(0)=1/√2 and c(k)=1 for every other k, within ±1. Sample x is two's complement at `in_samples[x*IN_W +: IN_W]`. Coefficient k is two's complement at `out_coefs[k*OUT_W +: OUT_W]`.
- R4: If all eight samples of a row are equal, coefficients 1 to 7 of that row are exactly zero.
- R5: If a row is antisymmetric (f(x) = −f(7−x) for every x), coefficients 0, 2, 4 and 6 of that row are exactly zero.
- R6: While `out_valid` is low, `out_coefs` keeps its last value. Input samples presented with `in_valid` low do not affect it.
- R7: Full-scale rows, both constant and alternating between the two extremes, still meet R3 without wrap-around. Every output magnitude stays at or below 3·2^(IN_W−1).
- R8: The block accepts one row on every clock. With or without gaps between rows, each sampled row gives exactly one result, in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when `in_samples` holds a row to transform |
| in_samples | input | 8*IN_W | Eight signed samples; sample x in bits [x*IN_W +: IN_W] |
| out_valid | output | 1 | High when `out_coefs` holds a new result |
| out_coefs | output | 8*OUT_W | Eight signed coefficients; coefficient k in bits [k*OUT_W +: OUT_W] |

## Verification
The assertions check four things on every cycle: that the valid flag arrives exactly four edges after the input, that constant rows give all-zero AC terms, that antisymmetric rows give all-zero even terms, and that idle outputs hold and stay in range. The numeric accuracy of each coefficient against the cosine sum can only be shown by the bench's scenarios. The same holds for result order with gaps between rows and for rows dropped by a reset in mid-flight. For these the bench computes the transform in real arithmetic and follows each row from entry to exit.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
    // Fraction bits of every multiplier constant
    localparam int CF  = 12;
    localparam int KW  = CF + 2;
    // Register stages from input to output
    localparam int LAT = 4;

    // Rotation constants, scale 1/2 folded in: A = k*cos, BMA = b-a, APB = a+b
    localparam int ROT1_A   = 2009;
    localparam int ROT1_BMA = -1609;
    localparam int ROT1_APB = 2409;
    localparam int ROT3_A   = 1703;
    localparam int ROT3_BMA = -565;
    localparam int ROT3_APB = 2841;
    localparam int ROT6_A   = 784;
    localparam int ROT6_BMA = 1108;
    localparam int ROT6_APB = 2676;
    // 1/sqrt(2) for the last odd butterfly, 1/(2*sqrt(2)) for DC and middle terms
    localparam int K_ISQ2   = 2896;
    localparam int K_DCNORM = 1448;
endpackage

// File: rtl/dct8_cmul.sv
module dct8_cmul
    import dct8_pkg::*;
#(
    parameter int W = 17,
    parameter int K = 0
) (
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    localparam int PW = W + KW;
    localparam logic signed [PW-1:0] KC   = PW'(K);
    localparam logic signed [PW-1:0] HALF = PW'(1 << (CF - 1));

    logic signed [PW-1:0] prod;

    // Constant product, rounded to nearest at CF fraction bits
    always_comb begin
        prod = PW'(din) * KC;
        dout = W'((prod + HALF) >>> CF);
    end
endmodule

// File: rtl/dct8_rot.sv
module dct8_rot
    import dct8_pkg::*;
#(
    parameter int W   = 17,
    parameter int A   = 0,
    parameter int BMA = 0,
    parameter int APB = 0
) (
    input  logic signed [W-1:0] i0,
    input  logic signed [W-1:0] i1,
    output logic signed [W-1:0] o0,
    output logic signed [W-1:0] o1
);
    logic signed [W-1:0] both;
    logic signed [W-1:0] p_shared;
    logic signed [W-1:0] p_hi;
    logic signed [W-1:0] p_lo;

    assign both = i0 + i1;

    dct8_cmul #(.W(W), .K(A))   u_shared (.din(both), .dout(p_shared));
    dct8_cmul #(.W(W), .K(BMA)) u_hi     (.din(i1),   .dout(p_hi));
    dct8_cmul #(.W(W), .K(APB)) u_lo     (.din(i0),   .dout(p_lo));

    // o0 = a*i0 + b*i1 ; o1 = a*i1 - b*i0, sharing a*(i0+i1)
    assign o0 = p_hi + p_shared;
    assign o1 = p_shared - p_lo;
endmodule

// File: rtl/dct8_fast.sv
module dct8_fast
    import dct8_pkg::*;
#(
    parameter int IN_W  = 9,
    parameter int OUT_W = 12,
    parameter int GF    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [8*IN_W-1:0]    in_samples,
    output logic                 out_valid,
    output logic [8*OUT_W-1:0]   out_coefs
);
    localparam int NPT   = 8;
    localparam int HALFN = NPT / 2;
    localparam int WI    = IN_W + 4 + GF;
    localparam int WRM_W = $clog2(LAT + 1);
    localparam int BOUND = 3 * (1 << (IN_W - 1));

    typedef logic signed [WI-1:0]    acc_t;
    typedef logic signed [OUT_W-1:0] coef_t;

    function automatic coef_t rnd_out(input acc_t v);
        acc_t t;
        t = (v + acc_t'(1 << (GF - 1))) >>> GF;
        return OUT_W'(t);
    endfunction

    // ---------------- valid pipeline ----------------
    logic [LAT-1:0] vld;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld <= '0;
        else        vld <= {vld[LAT-2:0], in_valid};
    end
    assign out_valid = vld[LAT-1];

    // ---------------- stage 1: mirrored butterfly ----------------
    acc_t x_ext [NPT];
    acc_t s1_sum [HALFN];
    acc_t s1_dif [HALFN];

    for (genvar g = 0; g < NPT; g++) begin : g_ext
        assign x_ext[g] = acc_t'($signed(in_samples[g*IN_W +: IN_W])) <<< GF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HALFN; i++) begin
                s1_sum[i] <= '0;
                s1_dif[i] <= '0;
            end
        end else if (in_valid) begin
            for (int i = 0; i < HALFN; i++) begin
                s1_sum[i] <= x_ext[i] + x_ext[NPT-1-i];
                s1_dif[i] <= x_ext[i] - x_ext[NPT-1-i];
            end
        end
    end

    // ---------------- stage 2: even butterfly, odd rotations ----------------
    acc_t ev_n [HALFN];
    acc_t u0_n, u1_n, v0_n, v1_n;
    acc_t s2_ev [HALFN];
    acc_t s2_u0, s2_u1, s2_v0, s2_v1;

    assign ev_n[0] = s1_sum[0] + s1_sum[3];
    assign ev_n[3] = s1_sum[0] - s1_sum[3];
    assign ev_n[1] = s1_sum[1] + s1_sum[2];
    assign ev_n[2] = s1_sum[1] - s1_sum[2];

    dct8_rot #(.W(WI), .A(ROT3_A), .BMA(ROT3_BMA), .APB(ROT3_APB)) u_rot3 (
        .i0(s1_dif[3]), .i1(s1_dif[0]), .o0(u0_n), .o1(u1_n));
    dct8_rot #(.W(WI), .A(ROT1_A), .BMA(ROT1_BMA), .APB(ROT1_APB)) u_rot1 (
        .i0(s1_dif[2]), .i1(s1_dif[1]), .o0(v0_n), .o1(v1_n));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HALFN; i++) s2_ev[i] <= '0;
            s2_u0 <= '0;
            s2_u1 <= '0;
            s2_v0 <= '0;
            s2_v1 <= '0;
        end else if (vld[0]) begin
            for (int i = 0; i < HALFN; i++) s2_ev[i] <= ev_n[i];
            s2_u0 <= u0_n;
            s2_u1 <= u1_n;
            s2_v0 <= v0_n;
            s2_v1 <= v1_n;
        end
    end

    // ---------------- stage 3: even outputs, odd butterfly ----------------
    acc_t dc_sum, dc_dif, dc_scl, mid_scl, r6_o0, r6_o1;
    acc_t s3_co [NPT];

    assign dc_sum = s2_ev[0] + s2_ev[1];
    assign dc_dif = s2_ev[0] - s2_ev[1];

    dct8_cmul #(.W(WI), .K(K_DCNORM)) u_dc  (.din(dc_sum), .dout(dc_scl));
    dct8_cmul #(.W(WI), .K(K_DCNORM)) u_mid (.din(dc_dif), .dout(mid_scl));
    dct8_rot #(.W(WI), .A(ROT6_A), .BMA(ROT6_BMA), .APB(ROT6_APB)) u_rot6 (
        .i0(s2_ev[2]), .i1(s2_ev[3]), .o0(r6_o0), .o1(r6_o1));

    // Slots 1 and 7 hold the two odd partial sums until stage 4
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NPT; k++) s3_co[k] <= '0;
        end else if (vld[1]) begin
            s3_co[0] <= dc_scl;
            s3_co[4] <= mid_scl;
            s3_co[2] <= r6_o0;
            s3_co[6] <= r6_o1;
            s3_co[1] <= s2_u1 + s2_v0;
            s3_co[7] <= s2_u0 + s2_v1;
            s3_co[3] <= s2_u1 - s2_v0;
            s3_co[5] <= s2_u0 - s2_v1;
        end
    end

    // ---------------- stage 4: last odd scaling and rounding ----------------
    acc_t pq_sum, pq_dif, f1_n, f7_n;
    acc_t fin [NPT];
    coef_t out_q [NPT];

    assign pq_sum = s3_co[1] + s3_co[7];
    assign pq_dif = s3_co[1] - s3_co[7];

    dct8_cmul #(.W(WI), .K(K_ISQ2)) u_f1 (.din(pq_sum), .dout(f1_n));
    dct8_cmul #(.W(WI), .K(K_ISQ2)) u_f7 (.din(pq_dif), .dout(f7_n));

    for (genvar k = 0; k < NPT; k++) begin : g_fin
        if (k == 1) begin : g_one
            assign fin[k] = f1_n;
        end else if (k == NPT - 1) begin : g_sev
            assign fin[k] = f7_n;
        end else begin : g_pass
            assign fin[k] = s3_co[k];
        end
        assign out_coefs[k*OUT_W +: OUT_W] = out_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NPT; k++) out_q[k] <= '0;
        end else if (vld[2]) begin
            for (int k = 0; k < NPT; k++) out_q[k] <= rnd_out(fin[k]);
        end
    end

    // ---------------- assertions ----------------
    localparam coef_t BOUND_P = OUT_W'(BOUND);

    logic [WRM_W-1:0] warm;
    logic in_flat, in_anti, ac_zero, even_zero, in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       warm <= '0;
        else if (warm != WRM_W'(LAT))     warm <= warm + 1'b1;
    end

    always_comb begin
        logic signed [IN_W:0] tot;
        in_flat = 1'b1;
        in_anti = 1'b1;
        for (int x = 1; x < NPT; x++)
            if (in_samples[x*IN_W +: IN_W] != in_samples[0 +: IN_W]) in_flat = 1'b0;
        for (int x = 0; x < HALFN; x++) begin
            tot = (IN_W+1)'($signed(in_samples[x*IN_W +: IN_W]))
                + (IN_W+1)'($signed(in_samples[(NPT-1-x)*IN_W +: IN_W]));
            if (tot != '0) in_anti = 1'b0;
        end
        ac_zero   = 1'b1;
        even_zero = 1'b1;
        in_range  = 1'b1;
        for (int k = 0; k < NPT; k++) begin
            if (k != 0 && out_q[k] != '0)       ac_zero   = 1'b0;
            if (k % 2 == 0 && out_q[k] != '0)   even_zero = 1'b0;
            if (out_q[k] > BOUND_P || out_q[k] < -BOUND_P) in_range = 1'b0;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == WRM_W'(LAT)) |-> (out_valid == $past(in_valid, LAT))); // R1
    AST_FLAT_AC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == WRM_W'(LAT)) && out_valid && $past(in_valid && in_flat, LAT)) |-> ac_zero); // R4
    AST_ANTI_EVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == WRM_W'(LAT)) && out_valid && $past(in_valid && in_anti, LAT)) |-> even_zero); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_coefs)); // R6
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_range); // R7
endmodule

// File: tb/dct8_fast_test.sv
module dct8_fast_test;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 9;
    localparam int OUT_W = 12;
    localparam int NROW  = 8;
    localparam real PI   = 3.14159265358979;

    // Stimulus table: flat, full-scale flat, alternating extremes, ramp, antisymmetric, mixed
    localparam int VEC [0:NROW-1][0:7] = '{
        '{   0,    0,   0,    0,   0,    0,    0,    0},
        '{ 100,  100, 100,  100, 100,  100,  100,  100},
        '{ 255,  255, 255,  255, 255,  255,  255,  255},
        '{-256, -256,-256, -256,-256, -256, -256, -256},
        '{ 255, -256, 255, -256, 255, -256,  255, -256},
        '{ -35,  -25, -15,   -5,   5,   15,   25,   35},
        '{ 200,  -50,  30,    7,  -7,  -30,   50, -200},
        '{  17,   -3, 250, -256,  99,    0, -128,   64}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [8*IN_W-1:0]  in_samples = '0;
    logic out_valid;
    logic [8*OUT_W-1:0] out_coefs;

    always #(CLK_PERIOD/2) clk = ~clk;

    dct8_fast #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(out_valid), .out_coefs(out_coefs));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int sent [0:63][0:7];
    int stamp [0:63];
    int n_push = 0;
    int n_pop = 0;
    int n_chk = 0;
    int n_bad = 0;

    task automatic report(input bit ok, input string tag, input string what,
                          input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0f expected %0f", tag, what, act, exp);
        end
    endtask

    function automatic real ref_coef(input int r, input int k);
        real acc = 0.0;
        for (int x = 0; x < 8; x++)
            acc += real'(sent[r][x]) * $cos(real'((2*x+1)*k) * PI / 16.0);
        return 0.5 * ((k == 0) ? 1.0 / $sqrt(2.0) : 1.0) * acc;
    endfunction

    function automatic int coef(input int k);
        return int'($signed(out_coefs[k*OUT_W +: OUT_W]));
    endfunction

    task automatic send_row(input int s[0:7]);
        @(negedge clk);
        in_valid = 1'b1;
        for (int x = 0; x < 8; x++) begin
            in_samples[x*IN_W +: IN_W] = IN_W'(s[x]);
            sent[n_push][x] = s[x];
        end
        stamp[n_push] = cyc + 1;
        n_push++;
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_samples = 72'({3{32'(cyc) * 32'h9E3779B1}});
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Output monitor: follows every sampled row to its result
    always @(negedge clk) begin
        bit flat, anti, full;
        int act;
        real exp, d;
        if (rst_n && out_valid) begin
            if (n_pop >= n_push) begin
                report(1'b0, "R8", "output with no row in flight", real'(n_pop), real'(n_push - 1));
            end else begin
                report(cyc - stamp[n_pop] == 3, "R1", "edges from sampling to result",
                       real'(cyc - stamp[n_pop] + 1), 4.0);
                flat = 1'b1; anti = 1'b1; full = 1'b0;
                for (int x = 0; x < 8; x++) begin
                    if (sent[n_pop][x] != sent[n_pop][0]) flat = 1'b0;
                    if (sent[n_pop][x] != -sent[n_pop][7-x]) anti = 1'b0;
                    if (sent[n_pop][x] == 255 || sent[n_pop][x] == -256) full = 1'b1;
                end
                for (int k = 0; k < 8; k++) begin
                    act = coef(k);
                    exp = ref_coef(n_pop, k);
                    d = real'(act) - exp;
                    if (d < 0.0) d = -d;
                    report(d <= 1.0, full ? "R7" : "R3", $sformatf("row %0d coef %0d", n_pop, k),
                           real'(act), exp);
                    if (flat && k != 0)
                        report(act == 0, "R4", $sformatf("flat row %0d coef %0d", n_pop, k), real'(act), 0.0);
                    if (anti && k % 2 == 0)
                        report(act == 0, "R5", $sformatf("antisym row %0d coef %0d", n_pop, k), real'(act), 0.0);
                end
            end
            n_pop++;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        report(1'b0, "R8", "watchdog expired", real'(n_pop), real'(n_push));
        finish_run();
    end

    initial begin
        logic [8*OUT_W-1:0] held;
        // R2: reset state, even with a valid row offered during reset
        in_valid = 1'b1;
        in_samples = 72'({8{9'd77}});
        repeat (3) @(negedge clk);
        report(out_valid == 1'b0, "R2", "out_valid in reset", real'(out_valid), 0.0);
        report(out_coefs == '0, "R2", "coefficients in reset", real'(out_coefs != '0), 0.0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // Table walk, rows back to back (R3, R4, R5, R7, R8)
        for (int i = 0; i < NROW; i++) send_row(VEC[i]);
        idle(6);
        report(n_pop == n_push, "R8", "results after back-to-back rows", real'(n_pop), real'(n_push));

        // R6: idle inputs toggle, outputs hold
        held = out_coefs;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_samples = 72'({3{32'(c + 5) * 32'h7F4A7C15}});
            report(out_valid == 1'b0 && out_coefs == held, "R6", "hold while idle",
                   real'(out_coefs != held), 0.0);
        end

        // R8: rows with gaps of different lengths
        send_row(VEC[4]);
        idle(1);
        send_row(VEC[6]);
        idle(2);
        send_row(VEC[7]);
        send_row(VEC[1]);
        idle(3);
        send_row(VEC[5]);
        idle(6);
        report(n_pop == n_push, "R8", "results after gapped rows", real'(n_pop), real'(n_push));

        // R2: reset while a row is in flight drops it
        send_row(VEC[7]);
        idle(1);
        @(negedge clk);
        rst_n = 1'b0;
        n_pop = n_push;
        @(negedge clk);
        report(out_valid == 1'b0, "R2", "out_valid after mid-run reset", real'(out_valid), 0.0);
        report(out_coefs == '0, "R2", "coefficients after mid-run reset", real'(out_coefs != '0), 0.0);
        rst_n = 1'b1;
        idle(6);
        report(n_pop == n_push, "R2", "no result from dropped row", real'(n_pop), real'(n_push));

        finish_run();
    end
endmodule